// File: doc/BRIEF.md
# Down-Spread Triangle Ratio Generator

This block supplies the division-ratio word for a fractional-N synthesizer used as a spread-spectrum clock source. It adds a signed fractional offset to a nominal integer ratio. The offset walks linearly downward from zero and then back up to zero, so the synthesized frequency follows a triangle that stays at or below nominal. This is a down spread. The whole profile is made in digital logic and is clocked by the reference-rate clock of the synthesizer loop, so no separate modulation clock is needed.

Software or a fixed configuration picks three values. The step sets the size of each offset change per reference clock. The half-period count sets how many clocks each slope lasts. Together they set the spread depth (step times half-period) and the modulation rate (reference rate divided by twice the half-period). For example, a 30 kHz triangle with roughly 4883 ppm of downward spread is set by choosing the half-period from the reference rate and the step from the wanted depth. The ratio word changes on every clock and the delta-sigma modulator consumes it on every clock. For that reason it is a plain registered output with no valid/ready handshake and no back-pressure. A modulator cannot stall its reference clock, so stalling the profile would only distort the triangle.

Top module: `tri_profile_gen`

## Requirements
- R1: While reset is asserted, `ratio_o` equals `nominal_i` * 65536 and `falling_o` is 1.
- R2: `ratio_o` carries the integer ratio in bits [23:16] and a 16-bit unsigned fraction in bits [15:0]. It equals `nominal_i`*65536 plus a signed offset that is never positive, so it never exceeds the nominal ratio.
- R3: On each enabled clock, the offset moves by the active step. It falls by the step while `falling_o` is 1 and rises by the step while `falling_o` is 0.
- R4: For an active half-period H, where a programmed value of 0 acts as 1:
  - each slope lasts H enabled clocks;
  - the lowest offset reached is -step*H;
  - one full triangle lasts 2H clocks.
- R5: `falling_o` is 1 for the first H clocks of a period and 0 for the next H clocks. It returns to 1 in the same cycle that the offset returns to zero.
- R6: One clock after `enable_i` is seen low, the offset is zero and `falling_o` is 1. When enable is asserted again, a new descent starts from zero.
- R7: New `step_i` and `half_i` values are taken only at a clock where enable is low, or at the clock that completes a period. A change during a period has no effect until that period ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock of the synthesizer loop |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Spread enable; low forces the nominal ratio |
| nominal_i | input | 8 | Nominal integer division ratio |
| step_i | input | 16 | Offset change per clock, in units of 2^-16 |
| half_i | input | 16 | Clocks per slope (0 treated as 1) |
| ratio_o | output | 24 | Integer.fraction division ratio word |
| falling_o | output | 1 | 1 while the offset is descending |

## Verification
Directed runs use a fixed step with half-periods of 4 and of 0. These separate a correct slope length and turnaround from an off-by-one count or from a zero count that never terminates. A step change in the middle of a descent tells correct period-boundary sampling apart from immediate use of the new value, which would make the triangle asymmetric. An enable drop in the middle of a slope tests the clearing path and the restart from zero. A long random run then mixes steps, half-periods, nominal values and enable gaps. It compares every clock against a bench model that places each cycle on the triangle.

// File: rtl/spread_tri_pkg.sv
package spread_tri_pkg;
  typedef enum logic {
    SLOPE_RISE = 1'b0,
    SLOPE_FALL = 1'b1
  } slope_e;
endpackage

// File: rtl/tri_setting_latch.sv
module tri_setting_latch #(
  parameter int STEP_W = 16,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STEP_W-1:0] step_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [STEP_W-1:0] step_q,
  output logic [HALF_W-1:0] half_last_q
);
  logic [HALF_W-1:0] half_last_d;

  // A programmed count of zero behaves as a one-clock slope.
  assign half_last_d = (half_i == '0) ? '0 : half_i - HALF_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= '0;
      half_last_q <= '0;
    end else if (load) begin
      step_q      <= step_i;
      half_last_q <= half_last_d;
    end
  end
endmodule

// File: rtl/tri_half_counter.sv
module tri_half_counter
  import spread_tri_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_last,
  output slope_e            slope_q,
  output logic              wrap
);
  logic [HALF_W-1:0] cnt_q;
  logic              term;

  assign term = (cnt_q == half_last);
  assign wrap = run && term && (slope_q == SLOPE_RISE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      slope_q <= SLOPE_FALL;
    end else if (!run) begin
      cnt_q   <= '0;
      slope_q <= SLOPE_FALL;
    end else if (term) begin
      cnt_q   <= '0;
      slope_q <= (slope_q == SLOPE_FALL) ? SLOPE_RISE : SLOPE_FALL;
    end else begin
      cnt_q   <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/tri_offset_acc.sv
module tri_offset_acc
  import spread_tri_pkg::*;
#(
  parameter int STEP_W = 16,
  parameter int OFF_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  slope_e                  slope,
  input  logic [STEP_W-1:0]       step,
  output logic signed [OFF_W-1:0] off_q
);
  logic signed [OFF_W-1:0] step_ext;

  assign step_ext = OFF_W'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    off_q <= '0;
    else if (!run)                 off_q <= '0;
    else if (slope == SLOPE_FALL)  off_q <= off_q - step_ext;
    else                           off_q <= off_q + step_ext;
  end
endmodule

// File: rtl/tri_profile_gen.sv
module tri_profile_gen
  import spread_tri_pkg::*;
#(
  parameter int NOM_W  = 8,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 16,
  parameter int HALF_W = 16,
  parameter int OFF_W  = 24,
  localparam int RATIO_W = NOM_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic [NOM_W-1:0]   nominal_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [HALF_W-1:0]  half_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               falling_o
);
  logic [STEP_W-1:0]       step_act;
  logic [HALF_W-1:0]       half_last;
  logic                    wrap;
  logic                    load;
  slope_e                  slope;
  logic signed [OFF_W-1:0] off_q;

  // Settings are taken while idle or at the top of the triangle only.
  assign load = !enable_i || wrap;

  tri_setting_latch #(.STEP_W(STEP_W), .HALF_W(HALF_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .step_i(step_i), .half_i(half_i),
    .step_q(step_act), .half_last_q(half_last)
  );

  tri_half_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(enable_i), .half_last(half_last),
    .slope_q(slope), .wrap(wrap)
  );

  tri_offset_acc #(.STEP_W(STEP_W), .OFF_W(OFF_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(enable_i), .slope(slope), .step(step_act),
    .off_q(off_q)
  );

  assign ratio_o   = {nominal_i, {FRAC_W{1'b0}}} + RATIO_W'(off_q);
  assign falling_o = (slope == SLOPE_FALL);
endmodule

// File: rtl/tri_profile_gen_chk.sv
module tri_profile_gen_chk #(
  parameter int NOM_W  = 8,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 16,
  parameter int OFF_W  = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      enable_i,
  input logic [NOM_W-1:0]          nominal_i,
  input logic [NOM_W+FRAC_W-1:0]   ratio_o,
  input logic                      falling_o,
  input logic signed [OFF_W-1:0]   off_q,
  input logic [STEP_W-1:0]         step_act
);
  logic [NOM_W+FRAC_W-1:0] nom_word;
  assign nom_word = {nominal_i, {FRAC_W{1'b0}}};

  AST_RATIO_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_o <= nom_word); // R2
  AST_IDLE_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (ratio_o == nom_word) && falling_o); // R6
  AST_FALL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && falling_o && step_act != '0) |=> off_q < $past(off_q)); // R3
  AST_RISE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !falling_o && step_act != '0) |=> off_q > $past(off_q)); // R3
  AST_TOP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(falling_o) |-> off_q == '0); // R5
  AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != '0) |-> $stable(step_act)); // R7
endmodule

bind tri_profile_gen tri_profile_gen_chk #(
  .NOM_W(NOM_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .nominal_i(nominal_i),
  .ratio_o(ratio_o), .falling_o(falling_o), .off_q(off_q), .step_act(step_act)
);

// File: tb/tri_profile_gen_tb.sv
module tri_profile_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable_i = 1'b0;
  logic [7:0]  nominal_i = 8'd100;
  logic [15:0] step_i = 16'd0;
  logic [15:0] half_i = 16'd0;
  logic [23:0] ratio_o;
  logic        falling_o;

  int errors = 0;
  int checks = 0;
  int m_n = 0, m_s = 0, m_h = 1;
  string tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_profile_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .nominal_i(nominal_i),
    .step_i(step_i), .half_i(half_i), .ratio_o(ratio_o), .falling_o(falling_o)
  );

  function automatic longint exp_off(int n, int s, int h);
    int d = (n < h) ? n : 2*h - n;
    return -longint'(s) * d;
  endfunction

  function automatic int eff_half(logic [15:0] h);
    return (h == 16'd0) ? 1 : int'(h);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One clock: update the model at the edge, compare at the falling edge.
  task automatic cycle();
    longint nom_w, exp_r;
    @(posedge clk);
    if (!enable_i) begin
      m_n = 0; m_s = int'(step_i); m_h = eff_half(half_i);
    end else begin
      m_n++;
      if (m_n == 2*m_h) begin
        m_n = 0; m_s = int'(step_i); m_h = eff_half(half_i);
      end
    end
    @(negedge clk);
    nom_w = longint'(nominal_i) * 65536;
    exp_r = nom_w + exp_off(m_n, m_s, m_h);
    check(longint'(ratio_o) == exp_r, tag, "ratio", longint'(ratio_o), exp_r);
    check(falling_o == (m_n < m_h), "R5", "falling", longint'(falling_o),
          longint'(m_n < m_h));
    check(longint'(ratio_o) <= nom_w, "R2", "ceiling", longint'(ratio_o), nom_w);
    if (m_n == m_h)
      check(longint'(ratio_o) == nom_w - longint'(m_s) * m_h, "R4", "depth",
            longint'(ratio_o), nom_w - longint'(m_s) * m_h);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R3", "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    #(CLK_PERIOD * 2 + 1);
    // R1: reset state
    check(ratio_o == 24'd100 * 65536, "R1", "reset ratio", longint'(ratio_o), 100*65536);
    check(falling_o == 1'b1, "R1", "reset falling", longint'(falling_o), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: idle gives nominal
    tag = "R6"; step_i = 16'd1000; half_i = 16'd4;
    for (int i = 0; i < 3; i++) cycle();

    // R3/R4: full triangles, half-period 4
    tag = "R3"; enable_i = 1'b1;
    for (int i = 0; i < 24; i++) cycle();

    // R4: zero half-period acts as one
    tag = "R4"; half_i = 16'd0; step_i = 16'd500;
    for (int i = 0; i < 20; i++) cycle();

    // R7: mid-period change waits for period end
    tag = "R7"; half_i = 16'd6; step_i = 16'd300;
    for (int i = 0; i < 8; i++) cycle();
    step_i = 16'd77; half_i = 16'd3;
    for (int i = 0; i < 20; i++) cycle();

    // R6: drop enable in mid-descent, then restart
    tag = "R6"; cycle(); cycle();
    enable_i = 1'b0; cycle(); cycle();
    enable_i = 1'b1;
    for (int i = 0; i < 10; i++) cycle();

    // Random mix
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      enable_i = ($urandom % 100) >= 2;
      if (($urandom % 100) < 5) step_i = 16'($urandom % 300);
      if (($urandom % 100) < 5) half_i = 16'($urandom % 41);
      if (($urandom % 100) < 1) nominal_i = 8'(40 + $urandom % 200);
      cycle();
    end

    summary();
    $finish;
  end
endmodule